// File: doc/BRIEF.md
# PATA PIO Cycle Sequencer

This block runs one programmed-I/O read or write cycle on a parallel ATA device bus for each request it accepts. A request carries a 5-bit target code that selects the chip selects and the three address lines, a direction bit, 16 bits of write data, and a flag choosing the 8-bit register timing set or the 16-bit data timing set. All timing values arrive as counts of clock ticks, so the host logic that owns the transfer mode loads them once and reuses them for every cycle.

The cycle has four timed phases. The address and chip selects are presented with both strobes high for a setup count. The read or write strobe is then held low for the active count, and stretched while the device holds IORDY low if IORDY checking is enabled, up to a fixed limit. After the strobe rises, the address stays valid for a recovery wait chosen from the cycle-time and recovery-time constraints. A one-cycle done pulse then returns the captured read data and a timeout flag.

The controller is a five-state machine. IDLE moves to SETUP on a request. SETUP moves to ACTIVE when the setup count has elapsed. ACTIVE moves to RECOVER either normally, when the active count is met and IORDY is ready or unchecked, or on timeout, when the IORDY limit is reached. RECOVER moves to DONE when the recovery wait has elapsed. DONE always returns to IDLE.

Top module: `pata_pio_seq`

## Requirements
- R1: After reset and whenever the block is idle, both chip selects, both strobes and data-bus enable are deasserted (chip selects and strobes high, `dd_oe` low), and `busy` and `done` are low.
- R2: Throughout SETUP, ACTIVE and RECOVER, `dev_cs0_n` equals target bit 0, `dev_cs1_n` equals target bit 1, and `dev_addr` equals target bits 4:2.
- R3: Before either strobe falls, both strobes stay high with the address presented for max(t1,1) clock cycles.
- R4: A write request pulls only `dev_wr_n` low, and a read request pulls only `dev_rd_n` low. The two strobes are never low together.
- R5: With IORDY ready or unchecked, the strobe stays low for max(t2,1) cycles, taking t2 from the register set when `req_reg8`=1 and from the data set when it is 0.
- R6: With `iordy_chk_en`=1 and IORDY held low, the strobe stays low for max(t2,51) cycles and `timeout` is high together with `done`. With `iordy_chk_en`=0, IORDY has no effect on the active length and `timeout` stays low.
- R7: After the strobe rises, the address stays valid for W cycles. Let A be the actual active length. W is t0-A when t0>A and t0-A>t2i, and t2i otherwise. For a write, W is raised to the hold count if that is larger. W is at least 1.
- R8: On a write, `dd_oe` is high and `dd_out` carries the request data for the whole active phase and for `hold_cnt` cycles after the strobe rises. `dd_oe` is low at all other times.
- R9: On a read, `rdata` holds the value on `dd_in` at the rising edge of the read strobe, and it is valid from the done pulse onward.
- R10: `busy` is high from acceptance through the one-cycle `done` pulse and low the cycle after. A request presented while busy is ignored and does not change the bus pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only in IDLE |
| req_target | input | 5 | bit0 CS0 level, bit1 CS1 level, bits 4:2 address |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| req_reg8 | input | 1 | 1 = register timing set, 0 = data timing set |
| req_wdata | input | 16 | Write data |
| iordy_chk_en | input | 1 | Enable IORDY stretching |
| t_setup | input | 8 | Setup count t1 |
| reg_t0 | input | 8 | Register set cycle count |
| reg_t2 | input | 8 | Register set active count |
| reg_t2i | input | 8 | Register set recovery count |
| dat_t0 | input | 8 | Data set cycle count |
| dat_t2 | input | 8 | Data set active count |
| dat_t2i | input | 8 | Data set recovery count |
| hold_cnt | input | 2 | Write data hold after strobe rise |
| iordy | input | 1 | Device ready, asynchronous |
| dd_in | input | 16 | Data bus input |
| dev_cs0_n | output | 1 | Chip select 0, active low |
| dev_cs1_n | output | 1 | Chip select 1, active low |
| dev_addr | output | 3 | Device address lines |
| dev_rd_n | output | 1 | Read strobe, active low |
| dev_wr_n | output | 1 | Write strobe, active low |
| dd_out | output | 16 | Data bus output value |
| dd_oe | output | 1 | Data bus output enable |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Captured read data |
| timeout | output | 1 | IORDY limit reached, valid with done |

## Verification
The stimulus covers both directions, both timing sets, and targets in both the command block and the control block. Timings are chosen so that one vector takes the recovery wait from the cycle-minus-active difference, another takes it from the recovery count, and a third is lengthened by the write hold. Zero setup and active counts show that the one-cycle minimum is applied. IORDY held low with checking on, once with t2 below the limit and once above it, tells the 51-tick cap apart from the programmed count. IORDY held low with checking off shows that the pin is ignored. A request held high during a cycle, with a different target, shows that the pins do not move.

// File: rtl/pata_pio_pkg.sv
package pata_pio_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_SETUP   = 3'd1,
        ST_ACTIVE  = 3'd2,
        ST_RECOVER = 3'd3,
        ST_DONE    = 3'd4
    } seq_state_e;

endpackage

// File: rtl/pata_iordy_sync.sv
module pata_iordy_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] shreg;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) shreg <= '0;
                else        shreg <= async_in;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) shreg <= '0;
                else        shreg <= {shreg[STAGES-2:0], async_in};
            end
        end
    endgenerate

    assign sync_out = shreg[STAGES-1];
endmodule

// File: rtl/pata_timing_sel.sv
module pata_timing_sel #(
    parameter int CW = 8
) (
    input  logic          use_reg,
    input  logic [CW-1:0] reg_cyc,
    input  logic [CW-1:0] reg_act,
    input  logic [CW-1:0] reg_rec,
    input  logic [CW-1:0] dat_cyc,
    input  logic [CW-1:0] dat_act,
    input  logic [CW-1:0] dat_rec,
    output logic [CW-1:0] sel_cyc,
    output logic [CW-1:0] sel_act,
    output logic [CW-1:0] sel_rec
);
    always_comb begin
        if (use_reg) begin
            sel_cyc = reg_cyc;
            sel_act = reg_act;
            sel_rec = reg_rec;
        end else begin
            sel_cyc = dat_cyc;
            sel_act = dat_act;
            sel_rec = dat_rec;
        end
    end
endmodule

// File: rtl/pata_recov_calc.sv
module pata_recov_calc #(
    parameter int LW = 9,
    parameter int HW = 2
) (
    input  logic [LW-1:0] cyc,
    input  logic [LW-1:0] act,
    input  logic [LW-1:0] rec,
    input  logic [HW-1:0] hold,
    input  logic          is_write,
    output logic [LW-1:0] wait_len
);
    logic [LW-1:0] diff;
    logic [LW-1:0] base;
    logic [LW-1:0] hold_ext;

    assign diff     = cyc - act;
    assign hold_ext = LW'(hold);

    always_comb begin
        if ((cyc > act) && (diff > rec)) base = diff;
        else                             base = rec;
        if (is_write && (hold_ext > base)) base = hold_ext;
        if (base == '0) wait_len = LW'(1);
        else            wait_len = base;
    end
endmodule

// File: rtl/pata_pio_seq.sv
module pata_pio_seq
    import pata_pio_pkg::*;
#(
    parameter int CW          = 8,
    parameter int HW          = 2,
    parameter int DW          = 16,
    parameter int TGT_W       = 5,
    parameter int SYNC_STAGES = 2,
    parameter int IORDY_LIMIT = 51
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [TGT_W-1:0] req_target,
    input  logic             req_write,
    input  logic             req_reg8,
    input  logic [DW-1:0]    req_wdata,
    input  logic             iordy_chk_en,
    input  logic [CW-1:0]    t_setup,
    input  logic [CW-1:0]    reg_t0,
    input  logic [CW-1:0]    reg_t2,
    input  logic [CW-1:0]    reg_t2i,
    input  logic [CW-1:0]    dat_t0,
    input  logic [CW-1:0]    dat_t2,
    input  logic [CW-1:0]    dat_t2i,
    input  logic [HW-1:0]    hold_cnt,
    input  logic             iordy,
    input  logic [DW-1:0]    dd_in,
    output logic             dev_cs0_n,
    output logic             dev_cs1_n,
    output logic [2:0]       dev_addr,
    output logic             dev_rd_n,
    output logic             dev_wr_n,
    output logic [DW-1:0]    dd_out,
    output logic             dd_oe,
    output logic             busy,
    output logic             done,
    output logic [DW-1:0]    rdata,
    output logic             timeout
);
    localparam int LW = CW + 1;
    localparam logic [LW-1:0] LIMIT = LW'(IORDY_LIMIT);
    localparam logic [LW-1:0] ONE   = LW'(1);

    seq_state_e state, nxt;

    logic [LW-1:0]    cnt, len, rec_len, t1_eff, t2_eff, act_q;
    logic [TGT_W-1:0] tgt_q;
    logic             wr_q, chk_q, to_q;
    logic [DW-1:0]    wdata_q, rdata_q;
    logic [CW-1:0]    t1_q, t0_q, t2_q, t2i_q;
    logic [HW-1:0]    hold_q;
    logic [CW-1:0]    sel_t0, sel_t2, sel_t2i;
    logic             rdy_s, act_met, end_ok, end_to;

    pata_iordy_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (iordy),
        .sync_out (rdy_s)
    );

    pata_timing_sel #(.CW(CW)) u_tsel (
        .use_reg (req_reg8),
        .reg_cyc (reg_t0),
        .reg_act (reg_t2),
        .reg_rec (reg_t2i),
        .dat_cyc (dat_t0),
        .dat_act (dat_t2),
        .dat_rec (dat_t2i),
        .sel_cyc (sel_t0),
        .sel_act (sel_t2),
        .sel_rec (sel_t2i)
    );

    pata_recov_calc #(.LW(LW), .HW(HW)) u_recov (
        .cyc      (LW'(t0_q)),
        .act      (act_q),
        .rec      (LW'(t2i_q)),
        .hold     (hold_q),
        .is_write (wr_q),
        .wait_len (rec_len)
    );

    // phase length helpers
    assign len     = cnt + ONE;
    assign t1_eff  = (t1_q == '0) ? ONE : LW'(t1_q);
    assign t2_eff  = (t2_q == '0) ? ONE : LW'(t2_q);
    assign act_met = (len >= t2_eff);
    assign end_ok  = act_met && (!chk_q || rdy_s);
    assign end_to  = act_met && chk_q && !rdy_s && (len >= LIMIT);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next-state decode
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (req_valid)          nxt = ST_SETUP;
            ST_SETUP:   if (len >= t1_eff)      nxt = ST_ACTIVE;
            ST_ACTIVE:  if (end_ok || end_to)   nxt = ST_RECOVER;
            ST_RECOVER: if (len >= rec_len)     nxt = ST_DONE;
            ST_DONE:                            nxt = ST_IDLE;
            default:                            nxt = ST_IDLE;
        endcase
    end

    // request capture, phase counter, active length and read capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            tgt_q   <= '1;
            wr_q    <= 1'b0;
            chk_q   <= 1'b0;
            wdata_q <= '0;
            t1_q    <= '0;
            t0_q    <= '0;
            t2_q    <= '0;
            t2i_q   <= '0;
            hold_q  <= '0;
            act_q   <= '0;
            to_q    <= 1'b0;
            rdata_q <= '0;
        end else begin
            if (nxt != state) cnt <= '0;
            else              cnt <= len;

            if (state == ST_IDLE && req_valid) begin
                tgt_q   <= req_target;
                wr_q    <= req_write;
                chk_q   <= iordy_chk_en;
                wdata_q <= req_wdata;
                t1_q    <= t_setup;
                t0_q    <= sel_t0;
                t2_q    <= sel_t2;
                t2i_q   <= sel_t2i;
                hold_q  <= hold_cnt;
                to_q    <= 1'b0;
            end

            if (state == ST_ACTIVE && (end_ok || end_to)) begin
                act_q <= len;
                to_q  <= !end_ok;
                if (!wr_q) rdata_q <= dd_in;
            end
        end
    end

    // output decode
    always_comb begin
        dev_cs0_n = 1'b1;
        dev_cs1_n = 1'b1;
        dev_addr  = 3'b000;
        dev_rd_n  = 1'b1;
        dev_wr_n  = 1'b1;
        dd_oe     = 1'b0;
        busy      = (state != ST_IDLE);
        done      = (state == ST_DONE);
        timeout   = (state == ST_DONE) && to_q;
        unique case (state)
            ST_SETUP, ST_ACTIVE, ST_RECOVER: begin
                dev_cs0_n = tgt_q[0];
                dev_cs1_n = tgt_q[1];
                dev_addr  = tgt_q[4:2];
                if (state == ST_ACTIVE) begin
                    dev_rd_n = wr_q;
                    dev_wr_n = !wr_q;
                    dd_oe    = wr_q;
                end
                if (state == ST_RECOVER)
                    dd_oe = wr_q && (cnt < LW'(hold_q));
            end
            default: ;
        endcase
        dd_out = dd_oe ? wdata_q : '0;
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/pata_pio_seq_chk.sv
module pata_pio_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       done,
    input logic       timeout,
    input logic       dev_rd_n,
    input logic       dev_wr_n,
    input logic       dev_cs0_n,
    input logic       dev_cs1_n,
    input logic [2:0] dev_addr,
    input logic       dd_oe
);
    p_idle_bus_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (dev_rd_n && dev_wr_n && dev_cs0_n && dev_cs1_n && !dd_oe));

    p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!dev_rd_n && !dev_wr_n));

    p_addr_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!dev_rd_n && $past(!dev_rd_n)) |-> ($stable(dev_addr) && $stable(dev_cs0_n) && $stable(dev_cs1_n)));

    p_oe_with_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_wr_n |-> dd_oe);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    p_done_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    p_timeout_with_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> done);

    p_strobe_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!dev_rd_n || !dev_wr_n) |-> busy);
endmodule

bind pata_pio_seq pata_pio_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .timeout   (timeout),
    .dev_rd_n  (dev_rd_n),
    .dev_wr_n  (dev_wr_n),
    .dev_cs0_n (dev_cs0_n),
    .dev_cs1_n (dev_cs1_n),
    .dev_addr  (dev_addr),
    .dd_oe     (dd_oe)
);

// File: tb/pata_pio_seq_test.sv
`timescale 1ns/1ps
module pata_pio_seq_test;
    typedef struct packed {
        logic [7:0]  t1;
        logic        reg8;
        logic        wr;
        logic        chk;
        logic        rdy;
        logic [4:0]  tgt;
        logic [7:0]  rt0;
        logic [7:0]  rt2;
        logic [7:0]  rt2i;
        logic [7:0]  dt0;
        logic [7:0]  dt2;
        logic [7:0]  dt2i;
        logic [1:0]  hold;
        logic [15:0] data;
    } vec_t;

    // t1 reg8 wr chk rdy tgt rt0 rt2 rt2i dt0 dt2 dt2i hold data
    localparam vec_t VECS [8] = '{
        '{8'd3, 1'b1, 1'b1, 1'b0, 1'b1, 5'd30, 8'd12, 8'd5, 8'd2, 8'd8,  8'd4,  8'd3, 2'd3, 16'h00A5},
        '{8'd2, 1'b0, 1'b0, 1'b0, 1'b1, 5'd2,  8'd12, 8'd5, 8'd2, 8'd8,  8'd4,  8'd3, 2'd3, 16'hBEEF},
        '{8'd1, 1'b1, 1'b0, 1'b1, 1'b1, 5'd25, 8'd6,  8'd5, 8'd4, 8'd8,  8'd4,  8'd3, 2'd2, 16'h0077},
        '{8'd0, 1'b0, 1'b1, 1'b0, 1'b1, 5'd2,  8'd6,  8'd5, 8'd4, 8'd0,  8'd0,  8'd0, 2'd1, 16'h1234},
        '{8'd2, 1'b1, 1'b0, 1'b1, 1'b0, 5'd10, 8'd60, 8'd5, 8'd2, 8'd8,  8'd4,  8'd3, 2'd1, 16'h0042},
        '{8'd1, 1'b0, 1'b1, 1'b0, 1'b0, 5'd2,  8'd6,  8'd5, 8'd4, 8'd10, 8'd6,  8'd1, 2'd2, 16'hC3C3},
        '{8'd2, 1'b1, 1'b1, 1'b0, 1'b1, 5'd14, 8'd5,  8'd4, 8'd1, 8'd8,  8'd4,  8'd3, 2'd3, 16'h005A},
        '{8'd1, 1'b0, 1'b0, 1'b1, 1'b0, 5'd2,  8'd6,  8'd5, 8'd4, 8'd70, 8'd60, 8'd5, 2'd0, 16'h9001}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [4:0]  req_target = 5'd0;
    logic        req_write = 1'b0;
    logic        req_reg8 = 1'b0;
    logic [15:0] req_wdata = 16'd0;
    logic        iordy_chk_en = 1'b0;
    logic [7:0]  t_setup = 8'd0, reg_t0 = 8'd0, reg_t2 = 8'd0, reg_t2i = 8'd0;
    logic [7:0]  dat_t0 = 8'd0, dat_t2 = 8'd0, dat_t2i = 8'd0;
    logic [1:0]  hold_cnt = 2'd0;
    logic        iordy = 1'b1;
    logic [15:0] dd_in = 16'd0;
    logic        dev_cs0_n, dev_cs1_n, dev_rd_n, dev_wr_n, dd_oe, busy, done, timeout;
    logic [2:0]  dev_addr;
    logic [15:0] dd_out, rdata;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    pata_pio_seq uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_target(req_target),
        .req_write(req_write), .req_reg8(req_reg8), .req_wdata(req_wdata),
        .iordy_chk_en(iordy_chk_en), .t_setup(t_setup),
        .reg_t0(reg_t0), .reg_t2(reg_t2), .reg_t2i(reg_t2i),
        .dat_t0(dat_t0), .dat_t2(dat_t2), .dat_t2i(dat_t2i),
        .hold_cnt(hold_cnt), .iordy(iordy), .dd_in(dd_in),
        .dev_cs0_n(dev_cs0_n), .dev_cs1_n(dev_cs1_n), .dev_addr(dev_addr),
        .dev_rd_n(dev_rd_n), .dev_wr_n(dev_wr_n), .dd_out(dd_out), .dd_oe(dd_oe),
        .busy(busy), .done(done), .rdata(rdata), .timeout(timeout)
    );

    task automatic check(input string req, input int actual, input int expected);
        total++;
        if (actual != expected) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    task automatic run_vec(input vec_t v, input bit poke, input int idx);
        int t2, t0, t2i, act, wait_len, rec, hold;
        int n_setup = 0, n_act = 0, n_rec = 0, oe_act = 0, oe_rec = 0;
        int addr_bad = 0, dir_bad = 0, data_bad = 0, busy_bad = 0, oe_setup = 0;
        bit seen_strobe = 0, got_done = 0, to_seen = 0;
        logic [15:0] rd_seen = 16'd0;

        t0  = v.reg8 ? int'(v.rt0)  : int'(v.dt0);
        t2  = v.reg8 ? int'(v.rt2)  : int'(v.dt2);
        t2i = v.reg8 ? int'(v.rt2i) : int'(v.dt2i);
        t2  = imax(t2, 1);
        act = (v.chk && !v.rdy) ? imax(t2, 51) : t2;
        wait_len = ((t0 > act) && (t0 - act > t2i)) ? (t0 - act) : t2i;
        hold = v.wr ? int'(v.hold) : 0;
        rec  = imax(imax(wait_len, hold), 1);

        @(negedge clk);
        iordy = v.rdy; dd_in = v.data; iordy_chk_en = v.chk;
        t_setup = v.t1; reg_t0 = v.rt0; reg_t2 = v.rt2; reg_t2i = v.rt2i;
        dat_t0 = v.dt0; dat_t2 = v.dt2; dat_t2i = v.dt2i; hold_cnt = v.hold;
        repeat (4) @(negedge clk);
        req_valid = 1'b1; req_target = v.tgt; req_write = v.wr;
        req_reg8 = v.reg8; req_wdata = v.data;
        @(negedge clk);
        req_valid = 1'b0;
        for (int c = 0; c < 400; c++) begin
            if (done) begin
                got_done = 1; to_seen = timeout; rd_seen = rdata;
                break;
            end
            if (!busy) busy_bad++;
            if ({dev_addr, dev_cs1_n, dev_cs0_n} != v.tgt) addr_bad++;
            if (!dev_rd_n && !dev_wr_n) dir_bad++;
            if (!dev_rd_n || !dev_wr_n) begin
                seen_strobe = 1;
                n_act++;
                if (v.wr ? !dev_rd_n : !dev_wr_n) dir_bad++;
                if (dd_oe) oe_act++;
                if (v.wr && dd_out != v.data) data_bad++;
                if (poke && n_act == 1) begin
                    req_valid = 1'b1; req_target = ~v.tgt;
                end
            end else if (!seen_strobe) begin
                n_setup++;
                if (dd_oe) oe_setup++;
            end else begin
                n_rec++;
                req_valid = 1'b0;
                if (dd_oe) begin
                    oe_rec++;
                    if (dd_out != v.data) data_bad++;
                end
            end
            @(negedge clk);
        end
        req_valid = 1'b0;
        check($sformatf("R10 vec%0d done pulse seen", idx), got_done, 1);
        check($sformatf("R3 vec%0d setup cycles", idx), n_setup, imax(v.t1, 1));
        check($sformatf("R5 vec%0d active cycles", idx), n_act, act);
        check($sformatf("R7 vec%0d recovery cycles", idx), n_rec, rec);
        check($sformatf("R6 vec%0d timeout flag", idx), int'(to_seen), int'(v.chk && !v.rdy));
        check($sformatf("R2 vec%0d target mismatches", idx), addr_bad, 0);
        check($sformatf("R4 vec%0d strobe direction errors", idx), dir_bad, 0);
        check($sformatf("R8 vec%0d oe in active", idx), oe_act, v.wr ? act : 0);
        check($sformatf("R8 vec%0d oe after strobe", idx), oe_rec, hold);
        check($sformatf("R8 vec%0d oe in setup plus data errors", idx), oe_setup + data_bad, 0);
        check($sformatf("R10 vec%0d busy during cycle", idx), busy_bad, 0);
        if (!v.wr) check($sformatf("R9 vec%0d read data", idx), int'(rd_seen), int'(v.data));
        @(negedge clk);
        check($sformatf("R10 vec%0d busy low after done", idx), int'(busy), 0);
        check($sformatf("R10 vec%0d done single cycle", idx), int'(done), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 reset cs/strobe levels", int'({dev_cs0_n, dev_cs1_n, dev_rd_n, dev_wr_n}), 15);
        check("R1 reset oe/busy/done", int'({dd_oe, busy, done}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 idle after reset", int'({dev_cs0_n, dev_cs1_n, dev_rd_n, dev_wr_n, dd_oe, busy}), 60);

        for (int i = 0; i < 8; i++) run_vec(VECS[i], 1'b0, i);

        // R10 request held during a busy cycle is ignored (pins checked for target)
        run_vec(VECS[0], 1'b1, 100);
        run_vec(VECS[1], 1'b1, 101);

        // R1 idle bus after all cycles
        repeat (3) @(negedge clk);
        check("R1 idle bus at end", int'({dev_cs0_n, dev_cs1_n, dev_rd_n, dev_wr_n, dd_oe, busy}), 60);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule